// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache Controller

This block sits between a signal-processing core's data port and a slower next memory level. It is two-way set associative and write-back. Lines are brought in only when a read misses. A write that misses is not allocated. Its word is put into a small write queue, and the queue drains to the lower level by itself, so the core goes on without waiting for that level.

To save data-array power, the first probe of a lookup enables only one data way. The way is chosen by a predictor that uses the set's valid bits and its one-bit pseudo-LRU state. A correct prediction returns read data one cycle after acceptance. A wrong prediction costs one more cycle, in which the other way is probed.

The core side takes one request at a time through a valid/ready handshake and answers reads with a one-cycle response pulse. The lower side is a single valid/ready request channel that carries line reads, line write-backs and single-word writes, plus a response strobe that returns a filled line.

Top module: `dcache2w`

## Requirements
- R1: After reset, req_ready is high and resp_valid and mem_req_valid are low. The core port takes one request at a time: the cycle after an acceptance, req_ready is low.
- R2: Every read returns the value of the most recent write to that word, or the lower level's content if the word was never written, whatever mix of hits, misses, queued writes and evictions came before. Each read gives exactly one one-cycle resp_valid pulse.
- R3: Two lines whose addresses map to the same set can be resident together, so reading both again issues no further line reads.
- R4: The first probe uses the predicted way: the only valid way if exactly one is valid, and the most recently used way if both are valid. A read hit in the predicted way raises resp_valid at the first clock edge after acceptance. A hit in the other way raises it at the second edge.
- R5: In any cycle, at most one data way is enabled.
- R6: A write hit updates the cached word, marks the line dirty and causes no lower-level request.
- R7: A dirty victim is sent as one line write (mem_req_op = 1) that carries the line's current data. This is issued before the line read for the missing line.
- R8: The victim is an invalid way if the set has one. Otherwise it is the least recently used way.
- R9: A read miss waits until the write queue is empty. It then issues one line read (mem_req_op = 0) at the line-aligned address and installs the line, so the next read of that line hits.
- R10: A write miss allocates no line and issues no line read. The word goes into the write queue and is later sent as a word write (mem_req_op = 2) with the byte-aligned word address and the data in bits [31:0]. The core's request completes without waiting for the lower level.
- R11: A read of a word held in the write queue returns the youngest queued value for that word, with the predicted-hit latency and without using the lower level.
- R12: The write queue holds 4 words. A write miss that finds it full holds req_ready low until an entry has drained.
- R13: A lower-level request that is not accepted keeps mem_req_valid, mem_req_op and mem_req_addr unchanged in the next cycle. Op code 3 is never issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | WORD_W | Write data |
| resp_valid | output | 1 | One-cycle read response strobe |
| resp_rdata | output | WORD_W | Read data |
| mem_req_valid | output | 1 | Lower-level request valid |
| mem_req_ready | input | 1 | Lower level accepts the request |
| mem_req_op | output | 2 | 0 line read, 1 line write, 2 word write |
| mem_req_addr | output | ADDR_W | Line-aligned for line ops, word-aligned for word writes |
| mem_req_wdata | output | LINE_BYTES*8 | Line data, or the word in the low bits |
| mem_rvalid | input | 1 | Line fill data valid |
| mem_rdata | input | LINE_BYTES*8 | Line fill data |

## Verification
The bench measures response latency so that it can tell correct predictions from mispredictions. A predictor that ignored the valid bits or tracked the wrong way would show two-cycle hits where one is required, and the reverse. It fills and dirties one set until it forces a dirty eviction. It then checks the order of lower-level operations and the written-back word. A design that dropped the write-back, or issued it after the fill, would return stale data or show the wrong order. Stalled lower-level handshakes keep queued writes in the queue. This exposes forwarding that picks an older duplicate, a full queue that overwrites an entry instead of stalling, and read misses that fetch a line before queued words reach memory. A long random phase with random lower-level readiness compares every read against a reference image.

// File: rtl/dcache2w.sv
module dcache2w #(
  parameter int SETS       = 64,
  parameter int LINE_BYTES = 16,
  parameter int WORD_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int WB_DEPTH   = 4
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_we,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [WORD_W-1:0]       req_wdata,
  output logic                    resp_valid,
  output logic [WORD_W-1:0]       resp_rdata,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [1:0]              mem_req_op,
  output logic [ADDR_W-1:0]       mem_req_addr,
  output logic [LINE_BYTES*8-1:0] mem_req_wdata,
  input  logic                    mem_rvalid,
  input  logic [LINE_BYTES*8-1:0] mem_rdata
);
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WBYTES = WORD_W / 8;
  localparam int WPL    = LINE_BYTES / WBYTES;
  localparam int BO_W   = $clog2(WBYTES);
  localparam int WO_W   = $clog2(WPL);
  localparam int OFF_W  = BO_W + WO_W;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int PTR_W  = $clog2(WB_DEPTH);
  localparam int CNT_W  = PTR_W + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_P1, S_P2, S_WFULL, S_DRAIN, S_EVICT, S_FILL, S_FWAIT
  } state_t;

  state_t st;
  logic              q_we;
  logic [ADDR_W-1:0] q_addr;
  logic [WORD_W-1:0] q_wdata;

  logic [TAG_W-1:0]  tag_q   [SETS][2];
  logic [LINE_W-1:0] data_q  [SETS][2];
  logic [1:0]        val_q   [SETS];
  logic [1:0]        dirty_q [SETS];
  logic [SETS-1:0]   lru_q;

  logic [ADDR_W-1:0] wb_addr [WB_DEPTH];
  logic [WORD_W-1:0] wb_data [WB_DEPTH];
  logic [PTR_W-1:0]  wb_head, wb_tail;
  logic [CNT_W-1:0]  wb_cnt;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WO_W-1:0]   wo;
  logic [1:0]        set_v;
  logic              pred, pw, hit_p, vic, vic_dirty;
  logic [1:0]        dway_en;
  logic [LINE_W-1:0] way_line;
  logic [WORD_W-1:0] hit_word;
  logic              fwd_hit;
  logic [WORD_W-1:0] fwd_data;
  logic              probing, rd_fwd, hit, retry, miss;
  logic              wb_full, wb_empty, wb_push, wb_pop, fsm_mem, fill_done;

  assign idx   = q_addr[OFF_W +: IDX_W];
  assign tag   = q_addr[ADDR_W-1 -: TAG_W];
  assign wo    = q_addr[BO_W +: WO_W];
  assign set_v = val_q[idx];

  // first probe: sole valid way, else most recently used way
  assign pred     = (set_v == 2'b10) ? 1'b1 : (set_v == 2'b11) ? ~lru_q[idx] : 1'b0;
  assign pw       = pred ^ (st == S_P2);
  assign hit_p    = set_v[pw] && (tag_q[idx][pw] == tag);
  assign probing  = (st == S_P1) || (st == S_P2);
  // data-array enables; only the enabled way's line is read
  assign dway_en  = probing ? (2'b01 << pw) : 2'b00;
  assign way_line = data_q[idx][pw];
  assign hit_word = way_line[wo*WORD_W +: WORD_W];

  assign vic       = !set_v[0] ? 1'b0 : !set_v[1] ? 1'b1 : lru_q[idx];
  assign vic_dirty = set_v[vic] && dirty_q[idx][vic];

  assign wb_full  = wb_cnt == CNT_W'(WB_DEPTH);
  assign wb_empty = wb_cnt == '0;

  always_comb begin
    logic [PTR_W-1:0] p;
    fwd_hit  = 1'b0;
    fwd_data = '0;
    for (int k = 0; k < WB_DEPTH; k++) begin
      p = wb_head + PTR_W'(k);
      if (CNT_W'(k) < wb_cnt && wb_addr[p][ADDR_W-1:BO_W] == q_addr[ADDR_W-1:BO_W]) begin
        fwd_hit  = 1'b1;
        fwd_data = wb_data[p];
      end
    end
  end

  assign rd_fwd    = (st == S_P1) && !q_we && fwd_hit;
  assign hit       = probing && !rd_fwd && hit_p;
  assign retry     = (st == S_P1) && !rd_fwd && !hit_p && (set_v == 2'b11);
  assign miss      = probing && !rd_fwd && !hit_p && !retry;
  assign wb_push   = q_we && (miss || st == S_WFULL) && !wb_full;
  assign fill_done = (st == S_FWAIT) && mem_rvalid;
  assign fsm_mem   = (st == S_EVICT) || (st == S_FILL);
  assign wb_pop    = !fsm_mem && !wb_empty && mem_req_ready;

  assign req_ready     = st == S_IDLE;
  assign mem_req_valid = fsm_mem || !wb_empty;
  assign mem_req_op    = (st == S_EVICT) ? 2'd1 : (st == S_FILL) ? 2'd0 : 2'd2;
  assign mem_req_addr  = (st == S_EVICT) ? {tag_q[idx][vic], idx, OFF_W'(0)} :
                         (st == S_FILL)  ? {tag, idx, OFF_W'(0)} : wb_addr[wb_head];
  assign mem_req_wdata = (st == S_EVICT) ? data_q[idx][vic] : LINE_W'(wb_data[wb_head]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      q_we       <= 1'b0;
      q_addr     <= '0;
      q_wdata    <= '0;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      lru_q      <= '0;
      for (int s = 0; s < SETS; s++) begin
        val_q[s]   <= 2'b00;
        dirty_q[s] <= 2'b00;
      end
    end else begin
      resp_valid <= 1'b0;
      unique case (st)
        S_IDLE: if (req_valid) begin
          q_we    <= req_we;
          q_addr  <= req_addr;
          q_wdata <= req_wdata;
          st      <= S_P1;
        end
        S_P1, S_P2: begin
          if (rd_fwd) begin
            resp_valid <= 1'b1;
            resp_rdata <= fwd_data;
            st         <= S_IDLE;
          end else if (hit) begin
            lru_q[idx] <= ~pw;
            if (q_we) dirty_q[idx][pw] <= 1'b1;
            else begin
              resp_valid <= 1'b1;
              resp_rdata <= hit_word;
            end
            st <= S_IDLE;
          end else if (retry) st <= S_P2;
          else if (q_we)      st <= wb_full ? S_WFULL : S_IDLE;
          else                st <= S_DRAIN;
        end
        S_WFULL: if (!wb_full) st <= S_IDLE;
        S_DRAIN: if (wb_empty) st <= vic_dirty ? S_EVICT : S_FILL;
        S_EVICT: if (mem_req_ready) begin
          dirty_q[idx][vic] <= 1'b0;
          st                <= S_FILL;
        end
        S_FILL:  if (mem_req_ready) st <= S_FWAIT;
        S_FWAIT: if (mem_rvalid) begin
          val_q[idx][vic]   <= 1'b1;
          dirty_q[idx][vic] <= 1'b0;
          lru_q[idx]        <= ~vic;
          resp_valid        <= 1'b1;
          resp_rdata        <= mem_rdata[wo*WORD_W +: WORD_W];
          st                <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (hit && q_we) data_q[idx][pw][wo*WORD_W +: WORD_W] <= q_wdata;
    if (fill_done) begin
      data_q[idx][vic] <= mem_rdata;
      tag_q[idx][vic]  <= tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_head <= '0;
      wb_tail <= '0;
      wb_cnt  <= '0;
    end else begin
      if (wb_push) wb_tail <= wb_tail + 1'b1;
      if (wb_pop)  wb_head <= wb_head + 1'b1;
      wb_cnt <= wb_cnt + CNT_W'(wb_push) - CNT_W'(wb_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (wb_push) begin
      wb_addr[wb_tail] <= {q_addr[ADDR_W-1:BO_W], BO_W'(0)};
      wb_data[wb_tail] <= q_wdata;
    end
  end
endmodule

// File: rtl/dcache2w_chk.sv
module dcache2w_chk #(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 4,
  parameter int CNT_W    = 3,
  parameter int WB_DEPTH = 4
)(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [1:0]        mem_req_op,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [1:0]        dway_en,
  input logic [CNT_W-1:0]  wb_cnt
);
  // R1
  one_at_a_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  // R2
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  // R5
  single_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dway_en));
  // R9
  line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_op != 2'd2 |-> mem_req_addr[OFF_W-1:0] == '0);
  // R12
  queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cnt <= CNT_W'(WB_DEPTH));
  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_op) && $stable(mem_req_addr));
  // R13
  op_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_op != 2'd3);
endmodule

bind dcache2w dcache2w_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .CNT_W(CNT_W), .WB_DEPTH(WB_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_op(mem_req_op),
  .mem_req_addr(mem_req_addr), .dway_en(dway_en), .wb_cnt(wb_cnt)
);

// File: tb/sim_dcache2w.sv
`timescale 1ns/1ps
module sim_dcache2w;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_we = 1'b0;
  logic [31:0]  req_addr = '0, req_wdata = '0;
  logic         req_ready, resp_valid;
  logic [31:0]  resp_rdata;
  logic         mem_req_valid, mem_req_ready;
  logic [1:0]   mem_req_op;
  logic [31:0]  mem_req_addr;
  logic [127:0] mem_req_wdata;
  logic         mem_rvalid;
  logic [127:0] mem_rdata;

  dcache2w u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_op(mem_req_op), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  always #4 clk = ~clk;

  logic [31:0] ref_mem [4096];
  logic [31:0] lmem    [4096];
  int checks = 0, errors = 0;
  int n_fill = 0, n_lwr = 0, n_wwr = 0;
  logic [1:0] op_prev, op_last;
  logic mem_stall = 1'b0, rand_rdy = 1'b0;
  int fill_cnt;
  logic [11:0] fill_idx;

  function automatic logic [31:0] seed_val(int i);
    return (i * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  function automatic logic [31:0] A(int tg, int s, int w);
    return 32'(tg * 1024 + s * 16 + w * 4);
  endfunction

  always @(negedge clk)
    mem_req_ready <= mem_stall ? 1'b0 : (rand_rdy ? 1'($urandom % 2) : 1'b1);

  always @(posedge clk) begin
    if (!rst_n) begin
      fill_cnt   <= 0;
      mem_rvalid <= 1'b0;
    end else begin
      mem_rvalid <= 1'b0;
      if (fill_cnt != 0) begin
        fill_cnt <= fill_cnt - 1;
        if (fill_cnt == 1) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= {lmem[fill_idx+3], lmem[fill_idx+2], lmem[fill_idx+1], lmem[fill_idx]};
        end
      end
      if (mem_req_valid && mem_req_ready) begin
        op_prev <= op_last;
        op_last <= mem_req_op;
        case (mem_req_op)
          2'd0: begin
            fill_idx <= mem_req_addr[13:2];
            fill_cnt <= 3;
            n_fill   <= n_fill + 1;
          end
          2'd1: begin
            for (int w = 0; w < 4; w++)
              lmem[mem_req_addr[13:2] + 12'(w)] <= mem_req_wdata[w*32 +: 32];
            n_lwr <= n_lwr + 1;
          end
          default: begin
            lmem[mem_req_addr[13:2]] <= mem_req_wdata[31:0];
            n_wwr <= n_wwr + 1;
          end
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    ref_mem[a[13:2]] = d;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d, output int lat);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!resp_valid) begin
      @(negedge clk);
      lat++;
    end
    d = resp_rdata;
  endtask

  task automatic rd_chk(input logic [31:0] a, input int exp_lat, input string r);
    logic [31:0] d;
    int lat;
    rd(a, d, lat);
    chk(d == ref_mem[a[13:2]], r, d, ref_mem[a[13:2]]);
    if (exp_lat >= 0) chk(lat == exp_lat, {r, " latency"}, 32'(lat), 32'(exp_lat));
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 1);
    chk(resp_valid == 1'b0, "R1 resp", 32'(resp_valid), 0);
    chk(mem_req_valid == 1'b0, "R1 mem", 32'(mem_req_valid), 0);
  endtask

  task automatic t_alloc;
    int f0;
    f0 = n_fill;
    rd_chk(A(1, 5, 2), -1, "R9 cold miss");
    chk(n_fill == f0 + 1, "R9 one fill", 32'(n_fill), 32'(f0 + 1));
    rd_chk(A(1, 5, 0), 1, "R4 sole valid way");
    chk(n_fill == f0 + 1, "R9 hit after fill", 32'(n_fill), 32'(f0 + 1));
    rd_chk(A(2, 5, 1), -1, "R8 invalid way chosen");
    rd_chk(A(1, 5, 3), 2, "R4 mispredict");
    rd_chk(A(1, 5, 3), 1, "R4 mru hit");
    rd_chk(A(2, 5, 0), 2, "R4 mispredict back");
    chk(n_fill == f0 + 2, "R3 both resident", 32'(n_fill), 32'(f0 + 2));
  endtask

  task automatic t_write_hit;
    int f0, l0, w0;
    f0 = n_fill; l0 = n_lwr; w0 = n_wwr;
    wr(A(2, 5, 1), 32'hCAFE0001);
    idle(6);
    chk(n_fill == f0 && n_lwr == l0 && n_wwr == w0, "R6 no traffic",
        32'(n_fill + n_lwr + n_wwr), 32'(f0 + l0 + w0));
    rd_chk(A(2, 5, 1), 1, "R6 updated word");
  endtask

  task automatic t_evict;
    int f0, l0;
    f0 = n_fill; l0 = n_lwr;
    rd_chk(A(3, 5, 0), -1, "R8 evict lru");
    chk(n_lwr == l0, "R8 clean victim", 32'(n_lwr), 32'(l0));
    rd_chk(A(4, 5, 2), -1, "R7 dirty evict");
    chk(n_lwr == l0 + 1, "R7 one line write", 32'(n_lwr), 32'(l0 + 1));
    chk({op_prev, op_last} == 4'b0100, "R7 write before fill", 32'({op_prev, op_last}), 32'h4);
    chk(lmem[A(2, 5, 1) >> 2] == 32'hCAFE0001, "R7 written data",
        lmem[A(2, 5, 1) >> 2], 32'hCAFE0001);
    rd_chk(A(3, 5, 1), 2, "R8 survivor");
    chk(n_fill == f0 + 2, "R8 survivor no fill", 32'(n_fill), 32'(f0 + 2));
    rd_chk(A(2, 5, 1), -1, "R7 refetch");
    rd_chk(A(1, 5, 2), -1, "R2 refetch clean");
  endtask

  task automatic t_wmiss;
    int f0, w0;
    f0 = n_fill; w0 = n_wwr;
    mem_stall = 1'b1;
    wr(A(7, 9, 2), 32'h11);
    wr(A(7, 9, 2), 32'h22);
    wr(A(8, 9, 0), 32'h33);
    chk(n_fill == f0 && n_wwr == w0, "R10 no lower access", 32'(n_fill + n_wwr), 32'(f0 + w0));
    rd_chk(A(7, 9, 2), 1, "R11 youngest forward");
    rd_chk(A(8, 9, 0), 1, "R11 forward");
    mem_stall = 1'b0;
    idle(10);
    chk(n_wwr == w0 + 3, "R10 drained words", 32'(n_wwr), 32'(w0 + 3));
    chk(lmem[A(7, 9, 2) >> 2] == 32'h22, "R10 drain order", lmem[A(7, 9, 2) >> 2], 32'h22);
    rd_chk(A(7, 9, 2), -1, "R10 read after drain");
    chk(n_fill == f0 + 1, "R10 no allocate on write", 32'(n_fill), 32'(f0 + 1));
  endtask

  task automatic t_full;
    int w0;
    w0 = n_wwr;
    mem_stall = 1'b1;
    for (int k = 0; k < 4; k++) wr(A(9, 12, k), 32'h100 + 32'(k));
    wr(A(9, 13, 0), 32'h200);
    for (int k = 0; k < 8; k++) begin
      chk(req_ready == 1'b0, "R12 full stall", 32'(req_ready), 0);
      @(negedge clk);
    end
    mem_stall = 1'b0;
    while (!req_ready) @(negedge clk);
    idle(12);
    chk(n_wwr == w0 + 5, "R12 all drained", 32'(n_wwr), 32'(w0 + 5));
    for (int k = 0; k < 4; k++) rd_chk(A(9, 12, k), -1, "R9 fill after drain");
    rd_chk(A(9, 13, 0), -1, "R12 stalled word");
  endtask

  task automatic t_random;
    rand_rdy = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      a = A(int'($urandom % 6), int'($urandom % 2), int'($urandom % 4));
      if ($urandom % 2 == 0) wr(a, $urandom);
      else rd_chk(a, -1, "R2 random");
    end
    rand_rdy = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin
      ref_mem[i] = seed_val(i);
      lmem[i] <= seed_val(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alloc();
    t_write_hit();
    t_evict();
    t_wmiss();
    t_full();
    t_random();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule